// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Recency Replacement

This block is a small, fully associative address translation buffer. Each slot holds a virtual base, a region length and a physical base, so a single slot covers a whole contiguous virtual region rather than one exact tag. Software-visible behaviour is limited to two operations: an insert, which writes a new region into the buffer, and a lookup, which searches all slots for a region containing a virtual address and returns the matching slot and the translated physical address.

Slots are kept in recency order. Empty slots are always used first. Once every slot is in use, an insert replaces the least recently used one. A lookup reorders the slots only when its caller asks for that. When regions overlap, the most recently used match wins. An insert and a lookup in the same cycle are handled as the lookup first, then the insert.

Top module: `range_tlb`

## Requirements
- R1: After reset every slot is empty, `resp_valid` is 0, and any lookup misses until an insert has been made.
- R2: A slot matches address `va` when `vbase <= va` and `vbase + size > va`; the end of the region is exclusive, and the sum is taken without wrap-around.
- R3: On a hit, `resp_pa` equals the slot's physical base ORed with bits [11:0] of the looked-up address, zero-extended.
- R4: While at least one slot is empty, an insert fills an empty slot and evicts nothing, so every region inserted since reset, up to the slot count, still hits.
- R5: An insert into a full buffer replaces the least recently used region, which then misses. The other regions are kept.
- R6: A hitting lookup with `lk_update` = 1 moves the matched region to the most recent position. A new insert places its region at the most recent position.
- R7: A lookup with `lk_update` = 0 leaves the recency order unchanged. This is seen through which region a later full-buffer insert evicts.
- R8: When several regions contain the address, the one most recently used or inserted is returned.
- R9: In a cycle with both an insert and a lookup, the lookup sees the contents and order from before the insert. Its promotion is applied before the insert chooses its victim.
- R10: The result of a lookup presented at a clock edge appears on the response outputs after that edge, with `resp_valid` = 1. `resp_valid` is 0 after any edge that had no lookup.
- R11: A miss drives `resp_hit` to 0. The other response data are then undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert a region this cycle |
| ins_vpn | input | 32 | Virtual base of the new region |
| ins_size | input | 32 | Length of the new region in bytes |
| ins_pbase | input | 32 | Physical base of the new region |
| lk_valid | input | 1 | Perform a lookup this cycle |
| lk_va | input | 32 | Virtual address to look up |
| lk_update | input | 1 | Promote the matched region on a hit |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup found a region |
| resp_vbase | output | 32 | Virtual base of the matched region |
| resp_size | output | 32 | Length of the matched region |
| resp_pbase | output | 32 | Physical base of the matched region |
| resp_pa | output | 32 | Translated physical address |

## Verification
Lookup results are due one clock after the edge that samples the lookup. Changes to contents and order made by an edge affect only lookups sampled at later edges. The bench drives inputs at the falling edge and updates its queue-based model at the rising edge, using the inputs it sampled there. It compares the outputs at the next falling edge, so every comparison takes place exactly one edge after its stimulus. Replacement order has no direct output. It is checked through the regions that miss after an insert into a full buffer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int TLB_VA_W = 32;
  parameter int TLB_PA_W = 32;

  typedef struct packed {
    logic [TLB_VA_W-1:0] vbase;
    logic [TLB_VA_W-1:0] size;
    logic [TLB_PA_W-1:0] pbase;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_range_match.sv
module tlb_range_match
  import tlb_pkg::*;
(
  input  tlb_entry_t           ent,
  input  logic                 ent_valid,
  input  logic [TLB_VA_W-1:0]  va,
  output logic                 hit
);
  logic [TLB_VA_W:0] end_excl;
  logic              above_base;
  logic              below_end;

  always_comb begin
    end_excl   = {1'b0, ent.vbase} + {1'b0, ent.size};
    above_base = (ent.vbase <= va);
    below_end  = (end_excl > {1'b0, va});
    hit        = ent_valid & above_base & below_end;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 8,
  parameter int RW = 4
) (
  input  logic [N-1:0]         match_vec,
  input  logic [N-1:0][RW-1:0] rank,
  output logic [N-1:0]         sel,
  output logic                 any
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      sel[i] = match_vec[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && match_vec[j] && (rank[j] < rank[i])) sel[i] = 1'b0;
      end
    end
    any = |match_vec;
  end
endmodule

// File: rtl/tlb_recency.sv
module tlb_recency #(
  parameter int N  = 8,
  parameter int RW = 4
) (
  input  logic [N-1:0]         valid_q,
  input  logic [N-1:0][RW-1:0] rank_q,
  input  logic                 promote,
  input  logic [N-1:0]         promote_sel,
  input  logic                 ins_en,
  output logic [N-1:0][RW-1:0] rank_d,
  output logic [N-1:0]         ins_slot
);
  localparam logic [RW-1:0] TAIL_RANK = RW'(N - 1);
  localparam logic [RW-1:0] PAST_END  = RW'(N);

  logic [N-1:0][RW-1:0] rank_mid;
  logic [RW-1:0]        promo_rank;
  logic [RW-1:0]        ins_rank;
  logic                 full;
  logic [N-1:0]         free_pick;
  logic [N-1:0]         tail_pick;
  logic                 seen_free;

  // step 1: lookup promotion
  always_comb begin
    promo_rank = '0;
    for (int i = 0; i < N; i++) begin
      if (promote_sel[i]) promo_rank = promo_rank | rank_q[i];
    end
    for (int i = 0; i < N; i++) begin
      rank_mid[i] = rank_q[i];
      if (promote && valid_q[i]) begin
        if (promote_sel[i])              rank_mid[i] = '0;
        else if (rank_q[i] < promo_rank) rank_mid[i] = rank_q[i] + 1'b1;
      end
    end
  end

  // step 2: choose the slot an insert will write
  always_comb begin
    full      = &valid_q;
    seen_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      free_pick[i] = ~valid_q[i] & ~seen_free;
      if (~valid_q[i]) seen_free = 1'b1;
      tail_pick[i] = valid_q[i] && (rank_mid[i] == TAIL_RANK);
    end
    ins_slot = full ? tail_pick : free_pick;
    ins_rank = full ? TAIL_RANK : PAST_END;
  end

  // step 3: insert at the most recent position
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank_d[i] = rank_mid[i];
      if (ins_en) begin
        if (ins_slot[i])                                 rank_d[i] = '0;
        else if (valid_q[i] && (rank_mid[i] < ins_rank)) rank_d[i] = rank_mid[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int OFFSET_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  input  logic [TLB_VA_W-1:0] ins_vpn,
  input  logic [TLB_VA_W-1:0] ins_size,
  input  logic [TLB_PA_W-1:0] ins_pbase,
  input  logic                lk_valid,
  input  logic [TLB_VA_W-1:0] lk_va,
  input  logic                lk_update,
  output logic                resp_valid,
  output logic                resp_hit,
  output logic [TLB_VA_W-1:0] resp_vbase,
  output logic [TLB_VA_W-1:0] resp_size,
  output logic [TLB_PA_W-1:0] resp_pbase,
  output logic [TLB_PA_W-1:0] resp_pa
);
  localparam int RW = $clog2(NUM_ENTRIES) + 1;

  tlb_entry_t                      ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]          valid_q, valid_d;
  logic [NUM_ENTRIES-1:0][RW-1:0]  rank_q, rank_d;
  logic [NUM_ENTRIES-1:0]          match_vec, pick_vec, ins_slot;
  logic                            any_hit;
  tlb_entry_t                      hit_ent;
  logic [TLB_PA_W-1:0]             pa_d;
  logic                            resp_valid_d, resp_hit_d, resp_data_en;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    tlb_range_match u_match (
      .ent       (ent_q[g]),
      .ent_valid (valid_q[g]),
      .va        (lk_va),
      .hit       (match_vec[g])
    );
  end

  tlb_pick #(.N(NUM_ENTRIES), .RW(RW)) u_pick (
    .match_vec (match_vec),
    .rank      (rank_q),
    .sel       (pick_vec),
    .any       (any_hit)
  );

  tlb_recency #(.N(NUM_ENTRIES), .RW(RW)) u_recency (
    .valid_q     (valid_q),
    .rank_q      (rank_q),
    .promote     (lk_valid & lk_update & any_hit),
    .promote_sel (pick_vec),
    .ins_en      (ins_valid),
    .rank_d      (rank_d),
    .ins_slot    (ins_slot)
  );

  // next-state
  always_comb begin
    hit_ent = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (pick_vec[i]) hit_ent = tlb_entry_t'(hit_ent | ent_q[i]);
    end
    pa_d         = hit_ent.pbase | TLB_PA_W'(lk_va[OFFSET_BITS-1:0]);
    resp_valid_d = lk_valid;
    resp_hit_d   = lk_valid & any_hit;
    resp_data_en = lk_valid & any_hit;
    valid_d      = ins_valid ? (valid_q | ins_slot) : valid_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      rank_q     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      rank_q     <= rank_d;
      resp_valid <= resp_valid_d;
      resp_hit   <= resp_hit_d;
    end
  end

  // region storage, written only by inserts
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ins_valid && ins_slot[i]) begin
        ent_q[i].vbase <= ins_vpn;
        ent_q[i].size  <= ins_size;
        ent_q[i].pbase <= ins_pbase;
      end
    end
  end

  // response data
  always_ff @(posedge clk) begin
    if (resp_data_en) begin
      resp_vbase <= hit_ent.vbase;
      resp_size  <= hit_ent.size;
      resp_pbase <= hit_ent.pbase;
      resp_pa    <= pa_d;
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk
  import tlb_pkg::*;
#(
  parameter int N           = 8,
  parameter int OFFSET_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic [TLB_VA_W-1:0] lk_va,
  input logic                ins_valid,
  input logic                resp_valid,
  input logic                resp_hit,
  input logic [TLB_VA_W-1:0] resp_vbase,
  input logic [TLB_VA_W-1:0] resp_size,
  input logic [TLB_PA_W-1:0] resp_pa,
  input logic [N-1:0]        valid_q
);
  a_r10_resp_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> resp_valid);
  a_r10_no_resp_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !resp_valid);
  a_r11_hit_only_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_valid);
  a_r3_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 resp_hit) |-> (resp_pa[OFFSET_BITS-1:0] == $past(lk_va[OFFSET_BITS-1:0])));
  a_r2_hit_inside_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 resp_hit) |-> ((resp_vbase <= $past(lk_va)) &&
      (({1'b0, resp_vbase} + {1'b0, resp_size}) > {1'b0, $past(lk_va)})));
  a_r4_fill_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !(&valid_q)) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
  a_r5_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_q) |=> (&valid_q));
endmodule

bind range_tlb range_tlb_chk #(.N(NUM_ENTRIES), .OFFSET_BITS(OFFSET_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_va      (lk_va),
  .ins_valid  (ins_valid),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_vbase (resp_vbase),
  .resp_size  (resp_size),
  .resp_pa    (resp_pa),
  .valid_q    (valid_q)
);

// File: tb/tb_range_tlb.sv
module tb_range_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid, lk_valid, lk_update;
  logic [31:0] ins_vpn, ins_size, ins_pbase, lk_va;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_vbase, resp_size, resp_pbase, resp_pa;

  always #2.5 clk = ~clk;

  range_tlb #(.NUM_ENTRIES(N), .OFFSET_BITS(12)) dut (.*);

  typedef struct {
    longint vb;
    longint sz;
    longint pb;
  } reg_t;

  reg_t   model[$];
  bit     exp_valid, exp_hit;
  reg_t   exp_ent;
  longint exp_pa;
  int     n_checks = 0;
  int     n_fail   = 0;
  bit     finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // model of one clock edge: lookup first, then insert
  task automatic model_edge(input bit ins, input longint vpn, input longint sz,
                            input longint pb, input bit lk, input longint va,
                            input bit upd);
    exp_valid = lk;
    exp_hit   = 0;
    if (lk) begin
      for (int i = 0; i < model.size(); i++) begin
        if (model[i].vb <= va && model[i].vb + model[i].sz > va) begin
          exp_hit = 1;
          exp_ent = model[i];
          exp_pa  = model[i].pb | (va & 64'hFFF);
          if (upd) begin
            model.delete(i);
            model.push_front(exp_ent);
          end
          break;
        end
      end
    end
    if (ins) begin
      reg_t r;
      r.vb = vpn; r.sz = sz; r.pb = pb;
      if (model.size() == N) void'(model.pop_back());
      model.push_front(r);
    end
  endtask

  task automatic step(input bit ins, input longint vpn, input longint sz,
                      input longint pb, input bit lk, input longint va,
                      input bit upd, input string tag);
    ins_valid = ins; ins_vpn = vpn[31:0]; ins_size = sz[31:0]; ins_pbase = pb[31:0];
    lk_valid  = lk;  lk_va   = va[31:0];  lk_update = upd;
    @(posedge clk);
    model_edge(ins, vpn, sz, pb, lk, va, upd);
    @(negedge clk);
    check(resp_valid == exp_valid, "R10", {tag, " resp_valid"}, resp_valid, exp_valid);
    if (exp_valid) begin
      check(resp_hit == exp_hit, exp_hit ? tag : "R11", {tag, " hit"}, resp_hit, exp_hit);
      if (exp_hit && resp_hit) begin
        check(resp_vbase == exp_ent.vb[31:0], tag, "vbase", resp_vbase, exp_ent.vb);
        check(resp_size  == exp_ent.sz[31:0], tag, "size",  resp_size,  exp_ent.sz);
        check(resp_pbase == exp_ent.pb[31:0], tag, "pbase", resp_pbase, exp_ent.pb);
        check(resp_pa    == exp_pa[31:0],     "R3",  "pa",  resp_pa,    exp_pa);
      end
    end
  endtask

  task automatic ins(input longint vpn, input longint sz, input longint pb, input string tag);
    step(1, vpn, sz, pb, 0, 0, 0, tag);
  endtask

  task automatic look(input longint va, input bit upd, input string tag);
    step(0, 0, 0, 0, 1, va, upd, tag);
  endtask

  initial begin
    rst_n = 0;
    ins_valid = 0; lk_valid = 0; lk_update = 0;
    ins_vpn = '0; ins_size = '0; ins_pbase = '0; lk_va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
    look(32'h1000, 1, "R1");
    check(resp_hit == 1'b0, "R11", "miss after reset", resp_hit, 0);

    // R2/R3: boundaries of one region
    ins(32'h1000, 32'h1000, 32'h8000_0000, "R2");
    look(32'h1000, 0, "R2");
    look(32'h1FFF, 0, "R2");
    look(32'h2000, 0, "R2");
    look(32'h0FFF, 0, "R2");
    look(32'h1ABC, 0, "R3");
    look(32'hFFFF_FFF0, 0, "R2");

    // R4: fill remaining slots
    for (int k = 1; k < N; k++) ins(longint'(k) * 32'h10000, 32'h1000, 32'h4000_0000 + k * 32'h10_0000, "R4");
    look(32'h1800, 0, "R4");
    for (int k = 1; k < N; k++) look(longint'(k) * 32'h10000 + 32'h123, 0, "R4");

    // R6/R5: promote oldest, then insert evicts next oldest
    look(32'h1004, 1, "R6");
    ins(32'h90000, 32'h2000, 32'h5000_0000, "R5");
    look(32'h10000, 0, "R5");
    look(32'h1004, 0, "R6");

    // R7: lookup without update does not save the oldest
    look(32'h20010, 0, "R7");
    ins(32'hA0000, 32'h1000, 32'h5100_0000, "R7");
    look(32'h20010, 0, "R7");

    // R8: overlapping regions, most recent wins
    ins(32'h0, 32'h40000, 32'h6000_0000, "R8");
    look(32'h1800, 0, "R8");
    look(32'h30020, 1, "R8");
    look(32'h1800, 1, "R8");
    look(32'h30020, 0, "R8");

    // R9: same-cycle insert and lookup
    step(1, 32'hB0000, 32'h1000, 32'h7000_0000, 1, 32'hB0010, 1, "R9");
    look(32'hB0010, 0, "R9");
    step(1, 32'hC0000, 32'h1000, 32'h7100_0000, 1, 32'h50040, 1, "R9");
    look(32'h50040, 0, "R9");
    look(32'h60040, 0, "R9");

    // mixed traffic against the model
    for (int t = 0; t < 600; t++) begin
      step($urandom_range(0, 2) == 0, longint'($urandom_range(0, 15)) * 32'h1000,
           longint'($urandom_range(1, 4)) * 32'h1000,
           longint'($urandom_range(0, 255)) << 12,
           $urandom_range(0, 3) != 0, longint'($urandom_range(0, 32'h14000)),
           $urandom_range(0, 1), "R8");
    end
    ins_valid = 0; lk_valid = 0;
    @(posedge clk); @(negedge clk);
    check(resp_valid == 1'b0, "R10", "idle resp_valid", resp_valid, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule